// File: doc/BRIEF.md
# Carry-Free Layered Approximate Multiplier

This block multiplies two unsigned operands of `WIDTH` bits (a multiple of four, default 8). It is purely combinational and has no carry chain inside the reduction. The multiplier operand is cut into groups of four bits. Each group selects four consecutive rows of partial products, called a layer. Every column of a layer is reduced on its own by a small function of at most six inputs. The layer results are then summed exactly, so all the error comes from the per-column reduction.

Inside a layer, the bottom three columns are exact. The third column takes the true carry from the second column, but its own carry-out is dropped. The middle columns, those holding four terms, keep only the parity of their terms. The column just above them ORs its parity with a predicted carry. The top two columns are added exactly together with a predicted carry, and their carry-out forms the layer MSB.

A predicted carry into column k is the OR of the ANDs of the three adjacent-row term pairs of column k-1. The compile-time parameter `MODE` selects one of two variants. In the plain XOR variant, the middle columns use parity alone. In the predicting variant, each middle column bit is also ORed with its predicted carry. This trades a few gates for a lower mean error.

Top module: `cfl_approx_mult`

## Requirements
- R1: If either operand is zero, `product` is zero.
- R2: `product` never exceeds the exact product of the two operands, in either mode.
- R3: `product[2:0]` always equals the low three bits of the exact product.
- R4: If `multiplicand` has at most one bit set, `product` equals the exact product.
- R5: If each four-bit group of `multiplier` (bits 4g+3..4g) has at most one bit set, `product` equals the exact product.
- R6: In the plain XOR mode (`MODE` = 0), a middle column's bit is the XOR of its four terms, with no carry in. At WIDTH 4, 15 x 15 gives 177.
- R7: In the predicting mode (`MODE` = 1), a middle column's bit is its parity ORed with the predicted carry from the column below. At WIDTH 4, 15 x 15 gives 185.
- R8: For the same operands, the predicting mode's result is never below the plain mode's result.
- R9: The carry leaving the third column of a layer is discarded. At WIDTH 4, 3 x 3 gives 1 in both modes.
- R10: Across all operand pairs with a nonzero exact product, the mean relative error of the predicting mode does not exceed that of the plain mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| multiplicand | input | WIDTH | Unsigned operand whose bits run along each row |
| multiplier | input | WIDTH | Unsigned operand; each bit enables one row, in groups of four per layer |
| product | output | 2*WIDTH | Approximate unsigned product |

## Verification
The hardest situation to reach is a layer where predicted carries stack up across neighbouring columns. This only happens when several adjacent rows and several adjacent bits are all set at once. Such a layer is also where the bound of R2 and the ordering of R8 could break. The stimulus therefore sweeps every operand pair of the 8-bit build, and the dense corners (all-ones operands) are part of that sweep. A pair of 4-bit builds is driven from the low nibbles and checked against hand-derived values for the dense and dropped-carry cases.

// File: rtl/cfl_pkg.sv
package cfl_pkg;

  typedef enum logic {
    MODE_XOR     = 1'b0,
    MODE_PREDICT = 1'b1
  } redMode_e;

  typedef struct packed {
    logic predMiddle;  // OR predicted carry into four-term columns
    logic predUpper;   // OR predicted carry into third-from-last column
    logic predTop;     // add predicted carry into top two columns
  } redStrobe_t;

endpackage

// File: rtl/cfl_ctrl.sv
module cfl_ctrl
  import cfl_pkg::*;
#(
  parameter redMode_e MODE = MODE_XOR
) (
  output redStrobe_t strobes
);

  assign strobes.predMiddle = (MODE == MODE_PREDICT);
  assign strobes.predUpper  = 1'b1;
  assign strobes.predTop    = 1'b1;

endmodule

// File: rtl/cfl_layer.sv
module cfl_layer
  import cfl_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] multiplicand,
  input  logic [3:0]       rowBits,
  input  redStrobe_t       strobes,
  output logic [WIDTH+3:0] layerSum
);

  localparam int COLS   = WIDTH + 3;
  localparam int EXTW   = WIDTH + 6;

  logic [EXTW-1:0]           padded;
  logic [COLS-1:0][3:0]      colTerm;
  logic [WIDTH+1:3]          predCarry;
  logic                      lowCarry;
  logic [2:0]                topSum;

  assign padded = {3'b000, multiplicand, 3'b000};

  // term of row j in local column k: multiplicand[k-j] & rowBits[j]
  for (genvar k = 0; k < COLS; k++) begin : g_col
    for (genvar j = 0; j < 4; j++) begin : g_row
      assign colTerm[k][j] = padded[k-j+3] & rowBits[j];
    end
  end

  for (genvar k = 3; k <= WIDTH + 1; k++) begin : g_pred
    assign predCarry[k] = (colTerm[k-1][0] & colTerm[k-1][1]) |
                          (colTerm[k-1][1] & colTerm[k-1][2]) |
                          (colTerm[k-1][2] & colTerm[k-1][3]);
  end

  // lowest two columns, exact
  assign layerSum[0] = ^colTerm[0];
  assign layerSum[1] = ^colTerm[1];
  assign lowCarry    = colTerm[1][0] & colTerm[1][1];

  // third column, exact bit, carry-out dropped
  assign layerSum[2] = (^colTerm[2]) ^ lowCarry;

  // four-term middle columns: two stages, no carry chain
  for (genvar k = 3; k < WIDTH; k++) begin : g_mid
    logic firstStage;
    logic secondStage;
    assign firstStage  = colTerm[k][0] ^ colTerm[k][1] ^
                         (colTerm[k][2] & strobes.predMiddle);
    assign secondStage = firstStage ^ colTerm[k][3] ^
                         (colTerm[k][2] & ~strobes.predMiddle);
    assign layerSum[k] = secondStage | (strobes.predMiddle & predCarry[k]);
  end

  // third-from-last column: parity with predicted carry
  assign layerSum[WIDTH] = (^colTerm[WIDTH]) |
                           (strobes.predUpper & predCarry[WIDTH]);

  // top two columns summed exactly with predicted carry; carry-out is MSB
  assign topSum = 3'(colTerm[WIDTH+1][0]) + 3'(colTerm[WIDTH+1][1]) +
                  3'(colTerm[WIDTH+1][2]) + 3'(colTerm[WIDTH+1][3]) +
                  3'(strobes.predTop & predCarry[WIDTH+1]) +
                  ((3'(colTerm[WIDTH+2][0]) + 3'(colTerm[WIDTH+2][1]) +
                    3'(colTerm[WIDTH+2][2]) + 3'(colTerm[WIDTH+2][3])) << 1);

  assign layerSum[WIDTH+3:WIDTH+1] = topSum;

endmodule

// File: rtl/cfl_combine.sv
module cfl_combine #(
  parameter int WIDTH  = 8,
  parameter int LAYERS = WIDTH / 4
) (
  input  logic [LAYERS*(WIDTH+4)-1:0] layerBus,
  output logic [2*WIDTH-1:0]          product
);

  localparam int LW = WIDTH + 4;
  localparam int PW = 2 * WIDTH;

  always_comb begin
    logic [PW-1:0] acc;
    logic [PW-1:0] ext;
    acc = '0;
    for (int l = 0; l < LAYERS; l++) begin
      ext         = '0;
      ext[LW-1:0] = layerBus[l*LW +: LW];
      acc         = acc + (ext << (4 * l));
    end
    product = acc;
  end

endmodule

// File: rtl/cfl_approx_mult.sv
module cfl_approx_mult
  import cfl_pkg::*;
#(
  parameter int       WIDTH = 8,
  parameter redMode_e MODE  = MODE_XOR
) (
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic [2*WIDTH-1:0] product
);

  localparam int LAYERS = WIDTH / 4;
  localparam int LW     = WIDTH + 4;

  redStrobe_t              strobes;
  logic [LAYERS*LW-1:0]    layerBus;

  cfl_ctrl #(.MODE(MODE)) u_ctrl (
    .strobes(strobes)
  );

  for (genvar l = 0; l < LAYERS; l++) begin : g_layer
    cfl_layer #(.WIDTH(WIDTH)) u_layer (
      .multiplicand(multiplicand),
      .rowBits     (multiplier[4*l +: 4]),
      .strobes     (strobes),
      .layerSum    (layerBus[l*LW +: LW])
    );
  end

  cfl_combine #(.WIDTH(WIDTH), .LAYERS(LAYERS)) u_combine (
    .layerBus(layerBus),
    .product (product)
  );

endmodule

// File: rtl/cfl_approx_mult_chk.sv
module cfl_approx_mult_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0]   multiplicand,
  input logic [WIDTH-1:0]   multiplier,
  input logic [2*WIDTH-1:0] product
);

  localparam int GROUPS = WIDTH / 4;
  localparam int PW     = 2 * WIDTH;

  logic [PW-1:0] exact;
  logic          sparseRows;

  always_comb begin
    exact      = PW'(multiplicand) * PW'(multiplier);
    sparseRows = 1'b1;
    for (int g = 0; g < GROUPS; g++) begin
      if ($countones(multiplier[4*g +: 4]) > 1) sparseRows = 1'b0;
    end
  end

  always_comb begin
    // R1
    zero_operand_chk: assert ((multiplicand != '0 && multiplier != '0) || product == '0)
      else $error("zero operand gave nonzero product");
    // R2
    no_excess_chk: assert (product <= exact)
      else $error("approximate product exceeds exact product");
    // R3
    low_bits_chk: assert (product[2:0] == exact[2:0])
      else $error("low product bits differ from exact");
    // R4
    single_bit_chk: assert ($countones(multiplicand) > 1 || product == exact)
      else $error("single-bit multiplicand not exact");
    // R5
    sparse_rows_chk: assert (!sparseRows || product == exact)
      else $error("sparse multiplier rows not exact");
  end

endmodule

bind cfl_approx_mult cfl_approx_mult_chk #(.WIDTH(WIDTH)) u_chk (
  .multiplicand(multiplicand),
  .multiplier  (multiplier),
  .product     (product)
);

// File: tb/sim_cfl_approx_mult.sv
module sim_cfl_approx_mult;
  import cfl_pkg::*;

  typedef struct packed {
    logic [7:0]  a;
    logic [7:0]  b;
    logic [15:0] exact;
    logic [7:0]  exact4;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  opA = '0;
  logic [7:0]  opB = '0;
  logic [15:0] prodPlain, prodPred;
  logic [7:0]  prod4Plain, prod4Pred;

  item_t sbQueue[$];
  item_t it;
  int    compared   = 0;
  int    mismatched = 0;
  bit    finished   = 1'b0;
  real   errPlain   = 0.0;
  real   errPred    = 0.0;
  int    nonZero    = 0;

  always #4 clk = ~clk;

  cfl_approx_mult #(.WIDTH(8), .MODE(MODE_XOR)) u0 (
    .multiplicand(opA), .multiplier(opB), .product(prodPlain));
  cfl_approx_mult #(.WIDTH(8), .MODE(MODE_PREDICT)) u1 (
    .multiplicand(opA), .multiplier(opB), .product(prodPred));
  cfl_approx_mult #(.WIDTH(4), .MODE(MODE_XOR)) u2 (
    .multiplicand(opA[3:0]), .multiplier(opB[3:0]), .product(prod4Plain));
  cfl_approx_mult #(.WIDTH(4), .MODE(MODE_PREDICT)) u3 (
    .multiplicand(opA[3:0]), .multiplier(opB[3:0]), .product(prod4Pred));

  task automatic checkEq(input string req, input logic [15:0] actual, input logic [15:0] expected);
    compared++;
    if (actual !== expected) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic checkLe(input string req, input logic [15:0] actual, input logic [15:0] bound);
    compared++;
    if (actual > bound) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected<=%0d", req, actual, bound);
    end
  endtask

  task automatic checkGe(input string req, input logic [15:0] actual, input logic [15:0] bound);
    compared++;
    if (actual < bound) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected>=%0d", req, actual, bound);
    end
  endtask

  function automatic bit sparseMult(input logic [7:0] b);
    return ($countones(b[3:0]) <= 1) && ($countones(b[7:4]) <= 1);
  endfunction

  task automatic drive(input logic [7:0] a, input logic [7:0] b);
    item_t x;
    @(posedge clk);
    opA      = a;
    opB      = b;
    x.a      = a;
    x.b      = b;
    x.exact  = 16'(a) * 16'(b);
    x.exact4 = 8'(a[3:0]) * 8'(b[3:0]);
    sbQueue.push_back(x);
  endtask

  // monitor: pop expected items and compare
  initial begin
    forever begin
      @(negedge clk);
      if (sbQueue.size() != 0) begin
        it = sbQueue.pop_front();
        checkLe("R2 plain", prodPlain, it.exact);
        checkLe("R2 predict", prodPred, it.exact);
        checkLe("R2 plain w4", {8'h00, prod4Plain}, {8'h00, it.exact4});
        checkLe("R2 predict w4", {8'h00, prod4Pred}, {8'h00, it.exact4});
        checkGe("R8", prodPred, prodPlain);
        checkGe("R8 w4", {8'h00, prod4Pred}, {8'h00, prod4Plain});
        checkEq("R3", {13'h0, prodPlain[2:0]}, {13'h0, it.exact[2:0]});
        checkEq("R3 predict", {13'h0, prodPred[2:0]}, {13'h0, it.exact[2:0]});
        if (it.a == 8'h00 || it.b == 8'h00) begin
          checkEq("R1", prodPlain, 16'h0);
          checkEq("R1 predict", prodPred, 16'h0);
        end
        if ($countones(it.a) <= 1) begin
          checkEq("R4", prodPlain, it.exact);
          checkEq("R4 predict", prodPred, it.exact);
        end
        if (sparseMult(it.b)) begin
          checkEq("R5", prodPlain, it.exact);
          checkEq("R5 predict", prodPred, it.exact);
        end
        if (it.exact != 16'h0) begin
          nonZero++;
          errPlain += (real'(it.exact) - real'(prodPlain)) / real'(it.exact);
          errPred  += (real'(it.exact) - real'(prodPred)) / real'(it.exact);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL R10 watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    real mrePlain;
    real mrePred;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: operands held at zero
    checkEq("R1 reset", prodPlain, 16'h0);
    checkEq("R1 reset predict", prodPred, 16'h0);
    @(posedge clk);
    rst = 1'b0;

    // dense nibble corner, hand-derived
    @(posedge clk);
    opA = 8'h0F;
    opB = 8'h0F;
    @(negedge clk);
    checkEq("R6", {8'h00, prod4Plain}, 16'd177);
    checkEq("R7", {8'h00, prod4Pred}, 16'd185);

    // dropped carry from third column
    @(posedge clk);
    opA = 8'h03;
    opB = 8'h03;
    @(negedge clk);
    checkEq("R9 plain", {8'h00, prod4Plain}, 16'd1);
    checkEq("R9 predict", {8'h00, prod4Pred}, 16'd1);

    // exhaustive sweep through the scoreboard
    for (int i = 0; i < 65536; i++) begin
      drive(i[7:0], i[15:8]);
    end
    wait (sbQueue.size() == 0);
    repeat (2) @(negedge clk);

    mrePlain = (nonZero > 0) ? errPlain / real'(nonZero) : 0.0;
    mrePred  = (nonZero > 0) ? errPred / real'(nonZero) : 0.0;
    $display("mean relative error: xor=%f predict=%f over %0d pairs", mrePlain, mrePred, nonZero);
    compared++;
    if (mrePred > mrePlain) begin
      mismatched++;
      $display("FAIL R10 actual=%f expected<=%f", mrePred, mrePlain);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule